// File: doc/BRIEF.md
# DRAM Timing Parameter Converter

The converter turns a set of DDR3 timing values into clock-cycle counts for a given operating frequency, and then builds packed timing words for a memory controller that runs at half the PHY clock. Each value arrives in nanoseconds, in picoseconds, or as a pair made of a minimum cycle count and a duration. The block converts each duration to cycles with either truncation or round-up. A paired timing takes whichever of its two forms is larger. The clock period is looked up in a five-entry speed-bin table to select the CAS latency and the CAS write latency.

A single start pulse begins a run. The block steps through the conversions one at a time on a shared restoring divider that produces one quotient bit per cycle. When every output is valid it raises `done` for one cycle. Cycle counts, latencies and words keep their values until a later run overwrites them. The frequency and parameter inputs must be held steady from the start pulse until `done`.

Top module: `dram_tconv`

## Requirements
- R1: Picosecond durations convert with round-up: `cyc_ras` = (ras_ps*MHz + 999999)/1000000, and `cyc_faw` is formed the same way from faw_ps.
- R2: Nanosecond durations convert with divisor 1000: `cyc_rfc` rounds up ((ns*MHz + 999)/1000), while `cyc_refi` and `cyc_wr` truncate (ns*MHz/1000).
- R3: `cyc_rtp`, `cyc_wtr` and `cyc_cke` each equal the larger of their minimum cycle input and the rounded-up picosecond conversion.
- R4: `cyc_ckesr` equals `cyc_cke` + 1, and `cyc_rasmax` equals 9 * `cyc_refi`.
- R5: The clock period is tCK = floor(1000000/MHz) ps. CL/CWL come from the first entry, in the order (5,5,[3000,3300)), (6,5,[2500,3300)), (8,6,[1875,2500)), (10,7,[1500,1875)), (11,8,[1250,1500)), for which min <= tCK < max.
- R6: When no entry matches (including MHz = 0), `err` is 1 and CL and CWL are 0. Otherwise `err` is 0.
- R7: With H(n) = (n+1)/2, `word_act` = {H(4+CWL+tWTR)[31:24], H(tFAW)[23:16], (tRASmax/1024)[15:8], H(tRAS)[7:0]}.
- R8: `word_turn` = {H(CWL)[31:24], H(CL)[23:16], H(CL+6-CWL)[15:8], H(4+CWL+tWTR)[7:0]}. These are the read-to-write and write-to-read gaps for burst length 8.
- R9: `word_rfsh` = {(tREFI/32)[31:16], 8'h00, H(tRFC)[7:0]}, and `word_pd` = {8'h00, H(tRTP)[23:16], H(tCKESR)[15:8], H(tCKE)[7:0]}.
- R10: `done` is high for exactly one cycle once all outputs of the run are valid. Those outputs then stay unchanged until the next start.
- R11: A start pulse that arrives while a run is in progress is ignored. The current run finishes at its normal time, and no extra `done` follows.
- R12: While reset is held, `done`, `err`, CL, CWL and all four words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a conversion run |
| clk_mhz | input | MHZ_W | Operating frequency in MHz |
| refi_ns | input | NS_W | Refresh interval, ns |
| rfc_ns | input | NS_W | Refresh cycle time, ns |
| wr_ns | input | NS_W | Write recovery, ns |
| ras_ps | input | PS_W | Activate-to-precharge, ps |
| faw_ps | input | PS_W | Four-activate window, ps |
| rtp_min_ck | input | CK_W | Read-to-precharge minimum cycles |
| rtp_ps | input | PS_W | Read-to-precharge, ps |
| wtr_min_ck | input | CK_W | Write-to-read minimum cycles |
| wtr_ps | input | PS_W | Write-to-read, ps |
| cke_min_ck | input | CK_W | CKE minimum pulse cycles |
| cke_ps | input | PS_W | CKE minimum pulse, ps |
| cyc_refi | output | CYC_W | Refresh interval in cycles |
| cyc_rfc | output | CYC_W | Refresh cycle in cycles |
| cyc_ras | output | CYC_W | tRAS in cycles |
| cyc_faw | output | CYC_W | tFAW in cycles |
| cyc_wr | output | CYC_W | Write recovery in cycles |
| cyc_rtp | output | CYC_W | tRTP in cycles |
| cyc_wtr | output | CYC_W | tWTR in cycles |
| cyc_cke | output | CYC_W | tCKE in cycles |
| cyc_ckesr | output | CYC_W | tCKESR in cycles |
| cyc_rasmax | output | CYC_W+4 | Maximum tRAS in cycles |
| cas_lat | output | 4 | Selected CL |
| cas_wlat | output | 4 | Selected CWL |
| word_act | output | 32 | Activation timing word |
| word_turn | output | 32 | Turnaround timing word |
| word_rfsh | output | 32 | Refresh timing word |
| word_pd | output | 32 | Power-down timing word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No speed bin matched |

## Verification
A divider step that goes wrong, or a job index that points at the wrong slot, corrupts exactly one cycle count. That count then shows up in two or three of the packed words. The fault becomes visible at the `done` pulse, about six hundred cycles after start, so every run compares each count and each word against values computed from the formulas. A sequencer that restarts on a second start moves `done` later by the gap between the two pulses, and this is caught by timing the run against an undisturbed one. Speed-bin boundaries are exercised at periods that land exactly on a table edge, such as 2500 ps and 1250 ps, and at periods that fall just past one.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int DIV_W = 64;
  localparam int DSR_W = 20;
  localparam int NBIN  = 5;
  localparam int BURST = 8;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_BIN, S_PACK} seq_t;

  typedef struct packed {
    logic [3:0]       cl;
    logic [3:0]       cwl;
    logic [DSR_W-1:0] tck_lo;
    logic [DSR_W-1:0] tck_hi;
  } bin_t;

  function automatic bin_t bin_entry(input int idx);
    bin_t b;
    case (idx)
      0:       b = '{cl: 4'd5,  cwl: 4'd5, tck_lo: 20'd3000, tck_hi: 20'd3300};
      1:       b = '{cl: 4'd6,  cwl: 4'd5, tck_lo: 20'd2500, tck_hi: 20'd3300};
      2:       b = '{cl: 4'd8,  cwl: 4'd6, tck_lo: 20'd1875, tck_hi: 20'd2500};
      3:       b = '{cl: 4'd10, cwl: 4'd7, tck_lo: 20'd1500, tck_hi: 20'd1875};
      default: b = '{cl: 4'd11, cwl: 4'd8, tck_lo: 20'd1250, tck_hi: 20'd1500};
    endcase
    return b;
  endfunction

  // half value rounded up, clipped to an 8-bit field
  function automatic logic [7:0] half8(input logic [31:0] x);
    return 8'((x + 32'd1) >> 1);
  endfunction
endpackage

// File: rtl/dtc_div.sv
module dtc_div #(
  parameter int DW = 64,
  parameter int VW = 20,
  parameter int QW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [QW-1:0] quot,
  output logic          rdy
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   acc_q, acc_d;
  logic [VW-1:0]   rem_q, rem_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            rdy_q, rdy_d;
  logic [VW:0]     trial;
  logic            fits;
  logic [VW:0]     diff;

  always_comb begin
    trial = {rem_q, acc_q[DW-1]};
    fits  = trial >= {1'b0, divisor};
    diff  = trial - {1'b0, divisor};
    acc_d = acc_q;
    rem_d = rem_q;
    cnt_d = cnt_q;
    rdy_d = 1'b0;
    if (go) begin
      acc_d = dividend;
      rem_d = '0;
      cnt_d = CNTW'(DW);
    end else if (cnt_q != '0) begin
      acc_d = {acc_q[DW-2:0], fits};
      rem_d = fits ? diff[VW-1:0] : trial[VW-1:0];
      cnt_d = cnt_q - CNTW'(1);
      rdy_d = (cnt_q == CNTW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      rem_q <= rem_d;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign quot = acc_q[QW-1:0];
  assign rdy  = rdy_q;
endmodule

// File: rtl/dtc_bin_sel.sv
module dtc_bin_sel
  import dtc_pkg::*;
#(
  parameter int TW = 20
) (
  input  logic [TW-1:0] tck,
  output logic [3:0]    cl,
  output logic [3:0]    cwl,
  output logic          miss
);
  logic [NBIN-1:0] hit;

  for (genvar g = 0; g < NBIN; g++) begin : g_bin
    localparam bin_t E = bin_entry(g);
    assign hit[g] = (TW'(E.tck_lo) <= tck) && (tck < TW'(E.tck_hi));
  end

  // lowest index wins: scan from the top so the first match overrides
  always_comb begin
    cl   = '0;
    cwl  = '0;
    miss = 1'b1;
    for (int i = NBIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        cl   = bin_entry(i).cl;
        cwl  = bin_entry(i).cwl;
        miss = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_tconv.sv
module dram_tconv
  import dtc_pkg::*;
#(
  parameter int MHZ_W = 12,
  parameter int NS_W  = 16,
  parameter int PS_W  = 20,
  parameter int CK_W  = 8,
  parameter int CYC_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [MHZ_W-1:0]   clk_mhz,
  input  logic [NS_W-1:0]    refi_ns,
  input  logic [NS_W-1:0]    rfc_ns,
  input  logic [NS_W-1:0]    wr_ns,
  input  logic [PS_W-1:0]    ras_ps,
  input  logic [PS_W-1:0]    faw_ps,
  input  logic [CK_W-1:0]    rtp_min_ck,
  input  logic [PS_W-1:0]    rtp_ps,
  input  logic [CK_W-1:0]    wtr_min_ck,
  input  logic [PS_W-1:0]    wtr_ps,
  input  logic [CK_W-1:0]    cke_min_ck,
  input  logic [PS_W-1:0]    cke_ps,
  output logic [CYC_W-1:0]   cyc_refi,
  output logic [CYC_W-1:0]   cyc_rfc,
  output logic [CYC_W-1:0]   cyc_ras,
  output logic [CYC_W-1:0]   cyc_faw,
  output logic [CYC_W-1:0]   cyc_wr,
  output logic [CYC_W-1:0]   cyc_rtp,
  output logic [CYC_W-1:0]   cyc_wtr,
  output logic [CYC_W-1:0]   cyc_cke,
  output logic [CYC_W-1:0]   cyc_ckesr,
  output logic [CYC_W+3:0]   cyc_rasmax,
  output logic [3:0]         cas_lat,
  output logic [3:0]         cas_wlat,
  output logic [31:0]        word_act,
  output logic [31:0]        word_turn,
  output logic [31:0]        word_rfsh,
  output logic [31:0]        word_pd,
  output logic               done,
  output logic               err
);
  localparam int NJOB = 9;
  localparam int JW   = $clog2(NJOB);
  localparam int RMW  = CYC_W + 4;
  localparam logic [JW-1:0] J_TCK = 0, J_REFI = 1, J_RFC = 2, J_RAS = 3, J_FAW = 4,
                            J_WR = 5, J_RTP = 6, J_WTR = 7, J_CKE = 8;
  localparam logic [DSR_W-1:0] PS_DIV = 20'd1000000;
  localparam logic [DSR_W-1:0] NS_DIV = 20'd1000;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  seq_t           st_q, st_d;
  logic [JW-1:0]  job_q, job_d;
  logic           div_go, div_rdy;
  logic [DIV_W-1:0] dvd, mhz_w;
  logic [DSR_W-1:0] dvs;
  logic [CK_W-1:0]  ckmin;
  logic [CYC_W-1:0] div_q, cand;
  logic [CYC_W-1:0] res_q [NJOB];
  logic           res_we, bin_we, pack_we;

  // sequencer next state
  always_comb begin
    st_d  = st_q;
    job_d = job_q;
    unique case (st_q)
      S_IDLE:  if (start) begin st_d = S_ISSUE; job_d = '0; end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT:  if (div_rdy) begin
                 if (job_q == J_CKE) st_d = S_BIN;
                 else begin st_d = S_ISSUE; job_d = job_q + JW'(1); end
               end
      S_BIN:   st_d = S_PACK;
      S_PACK:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign div_go  = (st_q == S_ISSUE);
  assign res_we  = (st_q == S_WAIT) && div_rdy;
  assign bin_we  = (st_q == S_BIN);
  assign pack_we = (st_q == S_PACK);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= S_IDLE;
      job_q <= '0;
    end else begin
      st_q  <= st_d;
      job_q <= job_d;
    end
  end

  // per-job dividend, divisor and cycle floor
  assign mhz_w = DIV_W'(clk_mhz);
  always_comb begin
    dvd   = '0;
    dvs   = NS_DIV;
    ckmin = '0;
    unique case (job_q)
      J_TCK:  begin dvd = DIV_W'(PS_DIV); dvs = DSR_W'(clk_mhz); end
      J_REFI: dvd = DIV_W'(refi_ns) * mhz_w;
      J_RFC:  dvd = DIV_W'(rfc_ns) * mhz_w + DIV_W'(NS_DIV - 1);
      J_RAS:  begin dvd = DIV_W'(ras_ps) * mhz_w + DIV_W'(PS_DIV - 1); dvs = PS_DIV; end
      J_FAW:  begin dvd = DIV_W'(faw_ps) * mhz_w + DIV_W'(PS_DIV - 1); dvs = PS_DIV; end
      J_WR:   dvd = DIV_W'(wr_ns) * mhz_w;
      J_RTP:  begin dvd = DIV_W'(rtp_ps) * mhz_w + DIV_W'(PS_DIV - 1); dvs = PS_DIV;
                    ckmin = rtp_min_ck; end
      J_WTR:  begin dvd = DIV_W'(wtr_ps) * mhz_w + DIV_W'(PS_DIV - 1); dvs = PS_DIV;
                    ckmin = wtr_min_ck; end
      J_CKE:  begin dvd = DIV_W'(cke_ps) * mhz_w + DIV_W'(PS_DIV - 1); dvs = PS_DIV;
                    ckmin = cke_min_ck; end
      default: ;
    endcase
  end

  dtc_div #(.DW(DIV_W), .VW(DSR_W), .QW(CYC_W)) u_div (
    .clk(clk), .rst_n(rst_i), .go(div_go), .dividend(dvd), .divisor(dvs),
    .quot(div_q), .rdy(div_rdy)
  );

  assign cand = (div_q >= CYC_W'(ckmin)) ? div_q : CYC_W'(ckmin);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int k = 0; k < NJOB; k++) res_q[k] <= '0;
    end else if (res_we) begin
      res_q[job_q] <= cand;
    end
  end

  assign cyc_refi   = res_q[J_REFI];
  assign cyc_rfc    = res_q[J_RFC];
  assign cyc_ras    = res_q[J_RAS];
  assign cyc_faw    = res_q[J_FAW];
  assign cyc_wr     = res_q[J_WR];
  assign cyc_rtp    = res_q[J_RTP];
  assign cyc_wtr    = res_q[J_WTR];
  assign cyc_cke    = res_q[J_CKE];
  assign cyc_ckesr  = res_q[J_CKE] + CYC_W'(1);
  assign cyc_rasmax = (RMW'(res_q[J_REFI]) << 3) + RMW'(res_q[J_REFI]);

  // speed bin
  logic [3:0] sel_cl, sel_cwl, cl_q, cwl_q;
  logic       sel_miss, err_q;
  dtc_bin_sel #(.TW(CYC_W)) u_bin (
    .tck(res_q[J_TCK]), .cl(sel_cl), .cwl(sel_cwl), .miss(sel_miss)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cl_q  <= '0;
      cwl_q <= '0;
      err_q <= 1'b0;
    end else if (bin_we) begin
      cl_q  <= sel_cl;
      cwl_q <= sel_cwl;
      err_q <= sel_miss;
    end
  end

  // packed words for the half-rate controller
  logic [31:0] wr2rd, rd2wr;
  logic [31:0] act_d, turn_d, rfsh_d, pd_d;
  logic [31:0] act_q, turn_q, rfsh_q, pd_q;
  logic        done_q;
  always_comb begin
    wr2rd  = 32'(BURST / 2) + 32'(cwl_q) + 32'(cyc_wtr);
    rd2wr  = 32'(cl_q) + 32'(BURST / 2 + 2) - 32'(cwl_q);
    act_d  = {half8(wr2rd), half8(32'(cyc_faw)), 8'(cyc_rasmax >> 10), half8(32'(cyc_ras))};
    turn_d = {half8(32'(cwl_q)), half8(32'(cl_q)), half8(rd2wr), half8(wr2rd)};
    rfsh_d = {16'(cyc_refi >> 5), 8'h00, half8(32'(cyc_rfc))};
    pd_d   = {8'h00, half8(32'(cyc_rtp)), half8(32'(cyc_ckesr)), half8(32'(cyc_cke))};
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      act_q  <= '0;
      turn_q <= '0;
      rfsh_q <= '0;
      pd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= pack_we;
      if (pack_we) begin
        act_q  <= act_d;
        turn_q <= turn_d;
        rfsh_q <= rfsh_d;
        pd_q   <= pd_d;
      end
    end
  end

  assign cas_lat   = cl_q;
  assign cas_wlat  = cwl_q;
  assign err       = err_q;
  assign word_act  = act_q;
  assign word_turn = turn_q;
  assign word_rfsh = rfsh_q;
  assign word_pd   = pd_q;
  assign done      = done_q;
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk #(
  parameter int CK_W  = 8,
  parameter int CYC_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             err,
  input logic [3:0]       cas_lat,
  input logic [3:0]       cas_wlat,
  input logic [CK_W-1:0]  rtp_min_ck,
  input logic [CK_W-1:0]  cke_min_ck,
  input logic [CYC_W-1:0] cyc_rtp,
  input logic [CYC_W-1:0] cyc_cke
);
  p_rtp_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cyc_rtp >= CYC_W'(rtp_min_ck));

  p_cke_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cyc_cke >= CYC_W'(cke_min_ck));

  p_bin_sane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (cas_lat >= 4'd5 && cas_wlat >= 4'd5 && cas_wlat <= cas_lat));

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (cas_lat == 4'd0 && cas_wlat == 4'd0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dram_tconv dtc_chk #(.CK_W(CK_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .cas_lat(cas_lat),
  .cas_wlat(cas_wlat), .rtp_min_ck(rtp_min_ck), .cke_min_ck(cke_min_ck),
  .cyc_rtp(cyc_rtp), .cyc_cke(cyc_cke)
);

// File: tb/dram_tconv_test.sv
`timescale 1ns/1ps
module dram_tconv_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start;
  logic [11:0] clk_mhz;
  logic [15:0] refi_ns, rfc_ns, wr_ns;
  logic [19:0] ras_ps, faw_ps, rtp_ps, wtr_ps, cke_ps;
  logic [7:0]  rtp_min_ck, wtr_min_ck, cke_min_ck;
  logic [19:0] cyc_refi, cyc_rfc, cyc_ras, cyc_faw, cyc_wr, cyc_rtp, cyc_wtr, cyc_cke, cyc_ckesr;
  logic [23:0] cyc_rasmax;
  logic [3:0]  cas_lat, cas_wlat;
  logic [31:0] word_act, word_turn, word_rfsh, word_pd;
  logic        done, err;

  dram_tconv uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  // {MHz, CL, CWL, err}
  localparam int NV = 9;
  localparam int VEC [NV][4] = '{
    '{333, 5, 5, 0}, '{400, 6, 5, 0}, '{480, 8, 6, 0}, '{533, 8, 6, 0},
    '{600, 10, 7, 0}, '{667, 11, 8, 0}, '{800, 11, 8, 0}, '{300, 0, 0, 1},
    '{1000, 0, 0, 1}};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint hf(input longint x);
    return ((x + 1) / 2) & 255;
  endfunction
  function automatic longint mx(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

  task automatic run(input int mhz, output int lat);
    int t0;
    @(negedge clk);
    clk_mhz = 12'(mhz);
    start = 1'b1;
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    while (!done && (cyc - t0) < 5000) @(negedge clk);
    if (!done) chk("R10 done never seen", 0, 1);
    lat = cyc - t0;
  endtask

  task automatic check_all(input int mhz, input int ecl, input int ecwl, input int eerr);
    longint m = mhz;
    longint e_refi = refi_ns * m / 1000;
    longint e_rfc  = (rfc_ns * m + 999) / 1000;
    longint e_wr   = wr_ns * m / 1000;
    longint e_ras  = (ras_ps * m + 999999) / 1000000;
    longint e_faw  = (faw_ps * m + 999999) / 1000000;
    longint e_rtp  = mx(rtp_min_ck, (rtp_ps * m + 999999) / 1000000);
    longint e_wtr  = mx(wtr_min_ck, (wtr_ps * m + 999999) / 1000000);
    longint e_cke  = mx(cke_min_ck, (cke_ps * m + 999999) / 1000000);
    longint w2r    = 4 + ecwl + e_wtr;
    chk("R1 ras", cyc_ras, e_ras);
    chk("R1 faw", cyc_faw, e_faw);
    chk("R2 rfc", cyc_rfc, e_rfc);
    chk("R2 refi", cyc_refi, e_refi);
    chk("R2 wr", cyc_wr, e_wr);
    chk("R3 rtp", cyc_rtp, e_rtp);
    chk("R3 wtr", cyc_wtr, e_wtr);
    chk("R3 cke", cyc_cke, e_cke);
    chk("R4 ckesr", cyc_ckesr, e_cke + 1);
    chk("R4 rasmax", cyc_rasmax, 9 * e_refi);
    chk("R5 cl", cas_lat, ecl);
    chk("R5 cwl", cas_wlat, ecwl);
    chk("R6 err", err, eerr);
    chk("R7 word_act", word_act,
        (hf(w2r) << 24) | (hf(e_faw) << 16) | ((((9 * e_refi) >> 10) & 255) << 8) | hf(e_ras));
    chk("R8 word_turn", word_turn,
        (hf(ecwl) << 24) | (hf(ecl) << 16) | (hf(ecl + 6 - ecwl) << 8) | hf(w2r));
    chk("R9 word_rfsh", word_rfsh, (((e_refi >> 5) & 65535) << 16) | hf(e_rfc));
    chk("R9 word_pd", word_pd, (hf(e_rtp) << 16) | (hf(e_cke + 1) << 8) | hf(e_cke));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat0, lat1, extra, t0;
    logic [31:0] held;
    rst_n = 1'b0; start = 1'b0; clk_mhz = 12'd400;
    refi_ns = 16'd7800; rfc_ns = 16'd260; wr_ns = 16'd15;
    ras_ps = 20'd35000; faw_ps = 20'd40000;
    rtp_min_ck = 8'd4; rtp_ps = 20'd7500;
    wtr_min_ck = 8'd4; wtr_ps = 20'd7500;
    cke_min_ck = 8'd3; cke_ps = 20'd5000;
    repeat (3) @(negedge clk);
    chk("R12 done in reset", done, 0);
    chk("R12 err in reset", err, 0);
    chk("R12 cl in reset", cas_lat, 0);
    chk("R12 cwl in reset", cas_wlat, 0);
    chk("R12 words in reset", word_act | word_turn | word_rfsh | word_pd, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][0], lat0);
      check_all(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      @(negedge clk);
      chk("R10 done single cycle", done, 0);
    end

    // outputs hold after completion
    held = word_turn;
    repeat (6) @(negedge clk);
    chk("R10 outputs held", word_turn, held);

    // cycle minimum dominates at a high clock
    rtp_min_ck = 8'd10; wtr_min_ck = 8'd9; cke_min_ck = 8'd7;
    run(800, lat0);
    check_all(800, 11, 8, 0);
    rtp_min_ck = 8'd4; wtr_min_ck = 8'd4; cke_min_ck = 8'd3;

    // zero frequency has no speed bin
    run(0, lat0);
    chk("R6 zero MHz err", err, 1);
    chk("R6 zero MHz cl", cas_lat, 0);

    // second start during a run is ignored
    run(400, lat0);
    @(negedge clk);
    clk_mhz = 12'd400;
    start = 1'b1;
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && (cyc - t0) < 5000) @(negedge clk);
    lat1 = cyc - t0;
    chk("R11 latency unchanged by busy start", lat1, lat0);
    check_all(400, 6, 5, 0);
    extra = 0;
    repeat (800) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R11 no extra done", extra, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule